// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and steers each one onto one of 15 request lines, or onto none. Software controls it through a small register port with address, write enable, write data and read data. One register holds the enable bits. A read-only register shows the raw source levels. Four routing registers hold a 4-bit destination code for every source.

A request line is high while at least one source that is routed to it is both high and enabled. The lines come from flip-flops, so each line follows a change in a source, an enable or a route one clock later. The sources are levels, so nothing has to be cleared: a request goes away when its source drops.

Routing fields fill the routing registers from the highest source down. Sources 24 to 31 sit in the first routing register and sources 0 to 7 sit in the last. Inside each register, the lowest source of its group of eight takes the lowest nibble.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset the enable register and all four routing registers read 0, and every request line is low.
- R2: The enable register (byte offset 0x00) and the routing registers at offsets 0x08, 0x0C, 0x10 and 0x14 (routing register 0 to 3) take a full 32-bit write when the write enable is high. The read data shows the addressed register in the cycle after the address is presented.
- R3: Offset 0x04 reads the current raw levels of the 32 sources, with bit n being source n. A write to offset 0x04 changes no register.
- R4: The routing code for source n sits in routing register 3 - n/8, at bits [4*(n%8)+3 : 4*(n%8)].
- R5: Routing code 0 connects the source to no line. Code k, for k from 1 to 15, connects it to request line k-1.
- R6: A source whose enable bit (bit n of offset 0x00) is 0 drives no request line, whatever its level and route.
- R7: Request line j is the flip-flop OR, over all sources, of source high AND enabled AND routed to j. It changes at the first clock edge after the change that causes it, and it falls when the last source holding it drops.
- R8: A read of any offset other than the six defined ones returns 0. A write to such an offset changes no register.
- R9: When a register is read and written in the same cycle, the read data shows the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| irq_src | input | 32 | Level-sensitive interrupt sources |
| irq_line | output | 15 | Routed request lines |

## Verification
Two pairs of actions can land in the same clock cycle. The first pair is a register write and a read of that same register. The bench writes the enable register while presenting its address and expects the old value on the next cycle and the new value only on a later read. The second pair is a source rising in the same cycle that its enable bit is written. The request line must stay low at the first edge, because that edge still sees the old enable, and go high at the second edge.

// File: rtl/lvl_irq_pkg.sv
// Package: shared sizes and register offsets for the routed level interrupt
// controller. Assumes byte addressing of 32-bit registers.
package lvl_irq_pkg;
    localparam int NUM_SRC   = 32;
    localparam int DATA_W    = 32;
    localparam int FIELD_W   = 4;
    localparam int ADDR_W    = 8;
    localparam int NUM_LINES = (1 << FIELD_W) - 1;
    localparam int PER_REG   = DATA_W / FIELD_W;
    localparam int ROUTE_REGS = NUM_SRC / PER_REG;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LEVEL  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ROUTE0 = 8'h08;
    localparam int                ROUTE_STEP = 4;
endpackage

// File: rtl/lir_regfile.sv
// Module: register file of the controller. It holds the enable register and
// the routing registers and gives registered read data one cycle after the
// address. Assumes single-cycle 32-bit accesses at exact offsets. Any other
// offset reads 0 and ignores writes.
module lir_regfile
    import lvl_irq_pkg::*;
#(
    parameter int P_SRC   = NUM_SRC,
    parameter int P_DATA  = DATA_W,
    parameter int P_ADDR  = ADDR_W,
    parameter int P_ROUTES = ROUTE_REGS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [P_ADDR-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [P_DATA-1:0]          bus_wdata,
    input  logic [P_SRC-1:0]           irq_src,
    output logic [P_DATA-1:0]          bus_rdata,
    output logic [P_SRC-1:0]           enable_q,
    output logic [P_ROUTES*P_DATA-1:0] route_flat
);
    logic [P_DATA-1:0] route_q [P_ROUTES];
    logic [P_ROUTES-1:0] route_hit;
    logic enable_hit, level_hit, any_hit;
    logic [P_DATA-1:0] rd_mux;
    logic [P_DATA-1:0] rdata_q;

    // Match the address against each defined offset.
    always_comb begin
        enable_hit = (bus_addr == OFS_ENABLE);
        level_hit  = (bus_addr == OFS_LEVEL);
        for (int r = 0; r < P_ROUTES; r++)
            route_hit[r] = (bus_addr == P_ADDR'(int'(OFS_ROUTE0) + ROUTE_STEP * r));
        any_hit = enable_hit | level_hit | (|route_hit);
    end

    // Update the enable register on a write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (bus_we && enable_hit)
            enable_q <= bus_wdata[P_SRC-1:0];
    end

    genvar g;
    generate
        for (g = 0; g < P_ROUTES; g++) begin : g_route
            // Update routing register g on a write to its offset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    route_q[g] <= '0;
                else if (bus_we && route_hit[g])
                    route_q[g] <= bus_wdata;
            end
            assign route_flat[g*P_DATA +: P_DATA] = route_q[g];
        end
    endgenerate

    // Select the read value from the state as it was before any write this cycle.
    always_comb begin
        rd_mux = '0;
        if (enable_hit) rd_mux = P_DATA'(enable_q);
        if (level_hit)  rd_mux = P_DATA'(irq_src);
        for (int r = 0; r < P_ROUTES; r++)
            if (route_hit[r]) rd_mux = route_q[r];
    end

    // Register the read data so that it is valid one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !any_hit) |=> ($stable(enable_q) && $stable(route_flat)));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> (bus_rdata == '0));

    // R3
    level_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && level_hit) |=> ($stable(enable_q) && $stable(route_flat)));
endmodule

// File: rtl/lir_route_decode.sv
// Module: turns every source's 4-bit routing code into a one-hot line select.
// The fields sit in reverse register order: source n is in routing register
// (ROUTES-1 - n/PER_REG), nibble n%PER_REG. Code 0 selects nothing.
module lir_route_decode
    import lvl_irq_pkg::*;
#(
    parameter int P_SRC   = NUM_SRC,
    parameter int P_DATA  = DATA_W,
    parameter int P_FIELD = FIELD_W,
    parameter int P_LINES = NUM_LINES
) (
    input  logic [(P_SRC*P_FIELD)-1:0] route_flat,
    output logic [P_SRC*P_LINES-1:0]   sel_flat
);
    localparam int L_PER_REG = P_DATA / P_FIELD;
    localparam int L_ROUTES  = P_SRC / L_PER_REG;

    genvar n, j;
    generate
        for (n = 0; n < P_SRC; n++) begin : g_src
            localparam int RIDX = L_ROUTES - 1 - n / L_PER_REG;
            localparam int BPOS = RIDX * P_DATA + P_FIELD * (n % L_PER_REG);
            logic [P_FIELD-1:0] code;
            assign code = route_flat[BPOS +: P_FIELD];
            for (j = 0; j < P_LINES; j++) begin : g_line
                assign sel_flat[n*P_LINES + j] = (code == P_FIELD'(j + 1));
            end
        end
    endgenerate
endmodule

// File: rtl/lir_line_or.sv
// Module: forms every request line as the OR of the sources that are high,
// enabled and routed to it, and registers the result. Assumes the sources
// are already synchronous to clk.
module lir_line_or
    import lvl_irq_pkg::*;
#(
    parameter int P_SRC   = NUM_SRC,
    parameter int P_LINES = NUM_LINES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [P_SRC-1:0]         irq_src,
    input  logic [P_SRC-1:0]         enable_q,
    input  logic [P_SRC*P_LINES-1:0] sel_flat,
    output logic [P_LINES-1:0]       irq_line
);
    logic [P_SRC-1:0]   live;
    logic [P_LINES-1:0] hit;
    logic [P_LINES-1:0] line_q;

    // OR together, for each line, the live sources that select it.
    always_comb begin
        live = irq_src & enable_q;
        hit  = '0;
        for (int j = 0; j < P_LINES; j++)
            for (int i = 0; i < P_SRC; i++)
                hit[j] = hit[j] | (live[i] & sel_flat[i*P_LINES + j]);
    end

    // Register the lines.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= '0;
        else
            line_q <= hit;
    end

    assign irq_line = line_q;

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_src & enable_q) == '0) |=> (irq_line == '0));

    // R7
    line_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_line) |-> $past(|(irq_src & enable_q)));
endmodule

// File: rtl/lvl_irq_router.sv
// Module: top of the routed level interrupt controller. It connects the
// register file, the route decoder and the line OR stage. Assumes a
// synchronous active-low reset and sources that are synchronous to clk.
module lvl_irq_router
    import lvl_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   irq_src,
    output logic [NUM_LINES-1:0] irq_line
);
    logic [NUM_SRC-1:0]           enable_q;
    logic [ROUTE_REGS*DATA_W-1:0] route_flat;
    logic [NUM_SRC*NUM_LINES-1:0] sel_flat;

    lir_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .irq_src(irq_src), .bus_rdata(bus_rdata),
        .enable_q(enable_q), .route_flat(route_flat)
    );

    lir_route_decode u_decode (
        .route_flat(route_flat), .sel_flat(sel_flat)
    );

    lir_line_or u_lines (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .enable_q(enable_q),
        .sel_flat(sel_flat), .irq_line(irq_line)
    );
endmodule

// File: tb/test_lvl_irq_router.sv
// Bench for lvl_irq_router: a table of routing vectors followed by directed tests.
module test_lvl_irq_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_src = '0;
    logic [14:0] irq_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    lvl_irq_router i_lvl_irq_router (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
        .irq_line(irq_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector table: source index, routing code, expected request lines.
    localparam int NVEC = 8;
    localparam int VEC_SRC [NVEC]  = '{0, 7, 8, 15, 16, 23, 24, 31};
    localparam int VEC_CODE [NVEC] = '{1, 15, 3, 0, 8, 2, 5, 14};
    localparam logic [14:0] VEC_LINE [NVEC] =
        '{15'h0001, 15'h4000, 15'h0004, 15'h0000, 15'h0080, 15'h0002, 15'h0010, 15'h2000};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    function automatic logic [7:0] route_ofs(input int n);
        return 8'(8 + 4 * (3 - n / 8));
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 lines", 32'(irq_line), 32'h0);
        rd(8'h00, v); chk("R1 enable", v, 32'h0);
        for (int r = 0; r < 4; r++) begin
            rd(8'(8 + 4*r), v); chk("R1 route", v, 32'h0);
        end

        // R4 R5 table walk
        wr(8'h00, 32'hFFFF_FFFF);
        for (int k = 0; k < NVEC; k++) begin
            for (int r = 0; r < 4; r++) wr(8'(8 + 4*r), 32'h0);
            wr(route_ofs(VEC_SRC[k]), 32'(VEC_CODE[k]) << (4 * (VEC_SRC[k] % 8)));
            @(negedge clk);
            irq_src = 32'h1 << VEC_SRC[k];
            @(negedge clk);
            chk("R4 R5 vector line", 32'(irq_line), 32'(VEC_LINE[k]));
            irq_src = '0;
            @(negedge clk);
        end
        for (int r = 0; r < 4; r++) wr(8'(8 + 4*r), 32'h0);

        // R2 read back
        wr(8'h00, 32'hA5A5_0F0F);
        rd(8'h00, v); chk("R2 enable readback", v, 32'hA5A5_0F0F);
        wr(8'h10, 32'h1234_5678);
        rd(8'h10, v); chk("R2 route readback", v, 32'h1234_5678);
        wr(8'h10, 32'h0);

        // R3 raw levels, write ignored
        @(negedge clk); irq_src = 32'hDEAD_BEEF;
        rd(8'h04, v); chk("R3 level read", v, 32'hDEAD_BEEF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R3 enable untouched", v, 32'hA5A5_0F0F);
        rd(8'h04, v); chk("R3 level after write", v, 32'hDEAD_BEEF);
        irq_src = '0;

        // R8 unmapped offsets
        wr(8'h18, 32'h5555_5555);
        rd(8'h18, v); chk("R8 unmapped read", v, 32'h0);
        wr(8'h02, 32'h0000_0001);
        rd(8'h02, v); chk("R8 unaligned read", v, 32'h0);
        rd(8'h00, v); chk("R8 enable untouched", v, 32'hA5A5_0F0F);
        rd(8'h08, v); chk("R8 route untouched", v, 32'h0);

        // R6: source 3 routed to line 0 (code 1 in register 3 nibble 3), enable off
        wr(8'h00, 32'h0);
        wr(8'h14, 32'h0000_1000);
        @(negedge clk); irq_src = 32'h0000_0008;
        @(negedge clk); @(negedge clk);
        chk("R6 masked line", 32'(irq_line), 32'h0);

        // R7 timing: line follows the enable write one edge after the register
        wr(8'h00, 32'h0000_0008);
        chk("R7 not yet", 32'(irq_line), 32'h0);
        @(negedge clk);
        chk("R7 line rises", 32'(irq_line), 32'h0001);

        // R7 OR of two sources on line 4 (code 5): source 3 and source 26
        wr(8'h14, 32'h0000_5000);
        wr(8'h08, 32'h0000_0500);
        wr(8'h00, 32'h0400_0008);
        @(negedge clk); irq_src = 32'h0400_0008;
        @(negedge clk);
        chk("R7 two sources", 32'(irq_line), 32'h0010);
        irq_src = 32'h0400_0000;
        @(negedge clk);
        chk("R7 one remains", 32'(irq_line), 32'h0010);
        irq_src = 32'h0;
        @(negedge clk);
        chk("R7 line falls", 32'(irq_line), 32'h0);

        // R9 read during write of the same register
        @(negedge clk);
        bus_addr = 8'h00; bus_we = 1'b1; bus_wdata = 32'h0000_00F0;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R9 old value", bus_rdata, 32'h0400_0008);
        @(negedge clk);
        chk("R9 new value", bus_rdata, 32'h0000_00F0);

        // R7 source rise and enable write in the same cycle (source 3, line 4)
        wr(8'h00, 32'h0);
        @(negedge clk);
        bus_addr = 8'h00; bus_we = 1'b1; bus_wdata = 32'h0000_0008;
        irq_src = 32'h0000_0008;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R7 same cycle first edge", 32'(irq_line), 32'h0);
        @(negedge clk);
        chk("R7 same cycle second edge", 32'(irq_line), 32'h0010);

        // R1 reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 lines after reset", 32'(irq_line), 32'h0);
        rd(8'h00, v); chk("R1 enable after reset", v, 32'h0);
        rd(8'h14, v); chk("R1 route after reset", v, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule